// File: doc/BRIEF.md
# Software Interrupt Raise Unit

This block sits in an interrupt distributor and turns a single register write into software interrupts for a set of processors. The writing CPU supplies one 32-bit word. The word names the interrupt number, from 0 to 15, and gives a bitmask of the CPUs that should receive it. For each selected target, the block sets a pending flag that also records which CPU made the request.

Pending state is held for every combination of target CPU, interrupt number and source CPU. If two CPUs raise the same number at the same target, the target receives it twice, and each delivery reports its own source. The CPU interface reads state through a query port. The query port gives the source that would be reported next for a (target, number) pair. An acknowledge input clears the flag for that one source only.

Top module: `sgi_raise_unit`

## Requirements
- R1: After reset, every bit of `pend_out` is 0 and the query port reports no hit.
- R2: A write from CPU s with target bit t set (word bit 16+t) and number n in word bits [3:0] sets the flag (t, n, s). From the next cycle, `pend_out[t*16+n]` is 1.
- R3: Word bits [15:4] have no effect on which number is raised.
- R4: Target bits at or above 16+NUM_CPUS are ignored. A write whose valid target field is all zero changes nothing.
- R5: The query for target `qry_cpu` and number `qry_id` returns `qry_hit`=1 and, in `qry_src`, the lowest-numbered source with a flag set for that pair. If no such flag is set, it returns `qry_hit`=0. A `qry_cpu` at or above NUM_CPUS always returns no hit.
- R6: An acknowledge for (target, number) clears only the flag of the lowest-numbered pending source. Any other sources stay pending, and the next query reports the next-lowest source.
- R7: The same number raised at one target by two different CPUs is held as two separate pending entries with distinct sources.
- R8: When a write sets a flag in the same cycle that an acknowledge would clear it, the flag ends up set.
- R9: A write whose `wr_cpu` is at or above NUM_CPUS has no effect.
- R10: An acknowledge with nothing pending for its pair, or with `ack_cpu` at or above NUM_CPUS, changes nothing. With no write and no acknowledge, the pending state holds.
- R11: One write with several target bits set raises the number at each of those targets independently. Acknowledging one target leaves the others pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe |
| wr_cpu | input | 3 | CPU number of the writer |
| wr_data | input | 32 | Written word: number in [3:0], target mask from bit 16 |
| ack_valid | input | 1 | Acknowledge strobe from the CPU interface |
| ack_cpu | input | 3 | Target CPU that acknowledges |
| ack_id | input | 4 | Interrupt number acknowledged |
| qry_cpu | input | 3 | Target CPU for the source query |
| qry_id | input | 4 | Interrupt number for the source query |
| qry_hit | output | 1 | Some source is pending for the queried pair |
| qry_src | output | 3 | Lowest pending source for the queried pair |
| pend_out | output | NUM_CPUS*16 | Per-target, per-number pending, bit t*16+n |

## Verification
The hardest case to reach is a new raise and an acknowledge landing on the same flag in the same cycle. This requires driving `wr_valid` and `ack_valid` together, with matching target and number. The bench does this twice. The first time, the writer is the source being acknowledged, so the flag must survive. The second time, a different CPU writes, so the acknowledged source must go and the new one must remain. The other ordering case, several sources queued on one pair, is set up by back-to-back writes from different CPUs. Acknowledges then drain those sources one at a time while the query port is checked between them.

// File: rtl/sgi_raise_unit.sv
module sgi_raise_unit #(
  parameter int unsigned NUM_CPUS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_valid,
  input  logic [2:0]               wr_cpu,
  input  logic [31:0]              wr_data,
  input  logic                     ack_valid,
  input  logic [2:0]               ack_cpu,
  input  logic [3:0]               ack_id,
  input  logic [2:0]               qry_cpu,
  input  logic [3:0]               qry_id,
  output logic                     qry_hit,
  output logic [2:0]               qry_src,
  output logic [NUM_CPUS*16-1:0]   pend_out
);
  localparam int unsigned NC = NUM_CPUS;
  localparam int unsigned NI = 16;
  localparam int unsigned NF = NC * NI * NC;

  logic [NF-1:0] flags, set_v, clr_v;
  logic          wr_ok, ack_ok;
  logic [NC-1:0] tgt_bits;
  logic [3:0]    wr_id;

  assign wr_ok    = wr_valid && (32'(wr_cpu) < NC);
  assign ack_ok   = ack_valid && (32'(ack_cpu) < NC);
  assign tgt_bits = wr_ok ? wr_data[16 +: NC] : '0;
  assign wr_id    = wr_data[3:0];

  for (genvar t = 0; t < NC; t++) begin : g_tgt
    for (genvar i = 0; i < NI; i++) begin : g_id
      localparam int unsigned G = (t * NI + i) * NC;
      logic [NC-1:0] grp, low;
      logic          hit_ack;
      assign grp     = flags[G +: NC];
      assign low     = grp & (~grp + {{(NC-1){1'b0}}, 1'b1});
      assign hit_ack = ack_ok && (ack_cpu == 3'(t)) && (ack_id == 4'(i));
      assign clr_v[G +: NC] = hit_ack ? low : '0;
      assign pend_out[t*NI + i] = |grp;
      for (genvar s = 0; s < NC; s++) begin : g_src
        assign set_v[G + s] = tgt_bits[t] && (wr_id == 4'(i)) && (wr_cpu == 3'(s));
      end
    end

    assert_raise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && (32'(wr_cpu) < NC) && wr_data[16+t])
        |=> pend_out[t*NI + 32'($past(wr_data[3:0]))]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_v) | set_v;
  end

  always_comb begin
    qry_hit = 1'b0;
    qry_src = 3'd0;
    if (32'(qry_cpu) < NC) begin
      for (int s = NC - 1; s >= 0; s--) begin
        if (flags[(32'(qry_cpu) * NI + 32'(qry_id)) * NC + s]) begin
          qry_hit = 1'b1;
          qry_src = 3'(s);
        end
      end
    end
  end

  assert_empty_list_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !ack_valid && (wr_data[16 +: NC] == '0)) |=> $stable(flags));

  assert_bad_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !ack_valid && (32'(wr_cpu) >= NC)) |=> $stable(flags));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid && !ack_valid) |=> $stable(pend_out));

  assert_single_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid) |=> ($countones(flags) + 1 >= $past($countones(flags))));

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && ack_valid && (32'(wr_cpu) < NC) && (32'(ack_cpu) < NC)
      && wr_data[16 + 32'(ack_cpu)] && (wr_data[3:0] == ack_id))
      |=> pend_out[32'($past(ack_cpu)) * NI + 32'($past(ack_id))]);
endmodule

// File: tb/sgi_raise_unit_test.sv
module sgi_raise_unit_test;
  localparam int NC = 4;
  logic clk = 0, rst_n = 0;
  logic wr_valid = 0, ack_valid = 0;
  logic [2:0] wr_cpu = 0, ack_cpu = 0, qry_cpu = 0;
  logic [31:0] wr_data = 0;
  logic [3:0] ack_id = 0, qry_id = 0;
  logic qry_hit;
  logic [2:0] qry_src;
  logic [NC*16-1:0] pend_out;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  sgi_raise_unit #(.NUM_CPUS(NC)) uut (.*);

  function automatic logic [63:0] pb(int t, int n);
    return 64'd1 << (t * 16 + n);
  endfunction

  task automatic chk_pend(string req, logic [63:0] exp);
    checks++;
    if (pend_out !== exp) begin
      errors++;
      $display("FAIL %s pend_out act=%h exp=%h", req, pend_out, exp);
    end
  endtask

  task automatic chk_q(string req, int t, int n, logic eh, logic [2:0] es);
    qry_cpu = 3'(t); qry_id = 4'(n); #1;
    checks++;
    if (qry_hit !== eh || (eh && qry_src !== es)) begin
      errors++;
      $display("FAIL %s query(%0d,%0d) act=%b/%0d exp=%b/%0d", req, t, n, qry_hit, qry_src, eh, es);
    end
  endtask

  task automatic cyc(logic wv, int wc, logic [31:0] wd, logic av, int ac, int ai);
    @(negedge clk);
    wr_valid = wv; wr_cpu = 3'(wc); wr_data = wd;
    ack_valid = av; ack_cpu = 3'(ac); ack_id = 4'(ai);
    @(negedge clk);
    wr_valid = 0; ack_valid = 0;
  endtask

  task automatic raise(int src, logic [15:0] mask, logic [15:0] low);
    cyc(1, src, {mask, low}, 0, 0, 0);
  endtask

  task automatic ack(int t, int n);
    cyc(0, 0, 0, 1, t, n);
  endtask

  task automatic t_reset;
    chk_pend("R1", 64'd0);
    chk_q("R1", 0, 0, 0, 0);
  endtask

  task automatic t_basic;
    raise(1, 16'h0005, 16'd5);
    chk_pend("R2 R11", pb(0,5) | pb(2,5));
    chk_q("R2", 0, 5, 1, 1);
    chk_q("R11", 2, 5, 1, 1);
    ack(0, 5);
    chk_pend("R11", pb(2,5));
    ack(2, 5);
    chk_pend("R11", 64'd0);
  endtask

  task automatic t_fields;
    raise(0, 16'h00F8, 16'hABC9);
    chk_pend("R3 R4", pb(3,9));
    raise(2, 16'h00F0, 16'd4);
    chk_pend("R4", pb(3,9));
    raise(2, 16'h0000, 16'd4);
    chk_pend("R4", pb(3,9));
    ack(3, 9);
    chk_pend("R4", 64'd0);
  endtask

  task automatic t_sources;
    raise(2, 16'h0002, 16'd7);
    raise(0, 16'h0002, 16'd7);
    chk_q("R5 R7", 1, 7, 1, 0);
    ack(1, 7);
    chk_pend("R6", pb(1,7));
    chk_q("R6", 1, 7, 1, 2);
    ack(1, 7);
    chk_pend("R6", 64'd0);
    chk_q("R5", 1, 7, 0, 0);
    chk_q("R5", 5, 7, 0, 0);
  endtask

  task automatic t_collide;
    raise(3, 16'h0001, 16'd2);
    cyc(1, 3, {16'h0001, 16'd2}, 1, 0, 2);
    chk_pend("R8", pb(0,2));
    chk_q("R8", 0, 2, 1, 3);
    cyc(1, 1, {16'h0001, 16'd2}, 1, 0, 2);
    chk_q("R8", 0, 2, 1, 1);
    ack(0, 2);
    chk_pend("R8", 64'd0);
  endtask

  task automatic t_ignored;
    raise(5, 16'h000F, 16'd1);
    chk_pend("R9", 64'd0);
    raise(3, 16'h0004, 16'd12);
    ack(2, 11);
    ack(6, 12);
    ack(1, 12);
    chk_pend("R10", pb(2,12));
    chk_q("R10", 2, 12, 1, 3);
    ack(2, 12);
    chk_pend("R10", 64'd0);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_basic;
    t_fields;
    t_sources;
    t_collide;
    t_ignored;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule